// File: doc/BRIEF.md
# Sum-of-Products Sequencer

This block computes a dot product Y = a1·x1 + a2·x2 + … + aN·xN, where the coefficients a and the samples x sit in byte-addressed memory as 16-bit halfwords. The caller supplies two start addresses (one for the coefficient table, one for the sample table), a tap count N and a one-cycle start pulse. The block then walks both tables through a single read port with a fixed one-cycle latency. It multiplies each signed coefficient by its signed sample and adds the 32-bit product into an accumulator.

The iteration is controlled like a software loop, not a hardware repeat. A down-counter is loaded with N. It drops by one after each multiply-accumulate, and a separate test step branches back to the next fetch while the counter is still nonzero. When the counter reaches zero, the block posts the sum on its result output and raises a one-cycle done pulse. The result then stays unchanged until the next job completes.

Top module: `sop_engine`

## Requirements
- R1: While reset is low at a clock edge, busy, done and the read request go low and the result goes to zero.
- R2: After a job, result equals the sum over k = 0..N-1 of signed(coef[k]) times signed(samp[k]), where each 16-bit product is formed as a full signed 32-bit value.
- R3: The sum wraps modulo 2^32. No saturation is applied: four products of 0x40000000 yield 0.
- R4: Term k first reads the coefficient at coef_ptr + 2k and, in the next cycle, the sample at samp_ptr + 2k. Read data is taken from rd_data one cycle after its request. Request runs are exactly two cycles long.
- R5: Each term takes four cycles: coefficient read, sample read, multiply-accumulate, and counter test. Busy is high from the cycle after the accepted start for 4N cycles.
- R6: A start with N = 0 raises done in the next cycle with result 0 and issues no read request.
- R7: A start pulse that arrives while busy is high is ignored. The running job's addresses, timing and result are unchanged.
- R8: Done is high for exactly one cycle, the cycle after the last counter test, and busy is low in that cycle.
- R9: The result output changes only in a cycle where done is high, and it holds its value otherwise.
- R10: A start in the cycle where done is high is accepted, so jobs can run back to back.
- R11: The read request is high only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle job start |
| coef_ptr_i | input | 32 | Byte address of the first coefficient |
| samp_ptr_i | input | 32 | Byte address of the first sample |
| taps_i | input | 16 | Number of terms N |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 32 | Byte address of the requested halfword |
| rd_data_i | input | 16 | Read data, valid one cycle after the request |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Sum of products of the last finished job |

## Verification
Jobs are run with one term, with a few terms of mixed signs, and with 40 random terms. These separate a correct signed multiply and an ordering of coefficient before sample from swapped or unsigned variants. Runs of the most negative coefficient times the most negative sample show wrap-around as opposed to saturation. A zero tap count shows that no read is issued. A second start during a job shows that the job is not restarted and does not pick up new pointers. A start placed exactly on the done cycle shows back-to-back acceptance. The bench predicts every request address and the busy, done and result values for each cycle, which also pins down the four-cycle term timing.

// File: rtl/sop_pkg.sv
// Shared types for the sum-of-products sequencer.
// Assumes nothing beyond a synthesizable enum encoding.
package sop_pkg;

    // Loop phases: idle, the two operand fetches, multiply-accumulate, and
    // the counter test that acts as the conditional branch.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FETCH_A = 3'd1,
        ST_FETCH_X = 3'd2,
        ST_MAC     = 3'd3,
        ST_CHECK   = 3'd4
    } sop_state_e;

endpackage

// File: rtl/sop_ctrl.sv
// Loop controller. Holds the phase register and the down-counter of
// remaining terms. The counter is loaded with the tap count on an accepted
// start and decremented in the multiply-accumulate phase. The test phase
// branches back to the fetch while the counter is nonzero and otherwise
// finishes with a one-cycle done pulse.
// Assumes start_i is sampled only while idle; starts during a job are dropped.
module sop_ctrl
    import sop_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] taps_i,
    output logic             busy_o,
    output logic             load_o,
    output logic             zero_o,
    output logic             fetch_a_o,
    output logic             fetch_x_o,
    output logic             mac_o,
    output logic             finish_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    sop_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             idle;
    logic             taps_zero;

    // Decode the phase into one strobe per datapath action.
    always_comb begin
        idle      = (state_q == ST_IDLE);
        taps_zero = (taps_i == CNT_ZERO);
        busy_o    = !idle;
        load_o    = idle && start_i && !taps_zero;
        zero_o    = idle && start_i && taps_zero;
        fetch_a_o = (state_q == ST_FETCH_A);
        fetch_x_o = (state_q == ST_FETCH_X);
        mac_o     = (state_q == ST_MAC);
        finish_o  = (state_q == ST_CHECK) && (cnt_q == CNT_ZERO);
        done_o    = done_q;
    end

    // Advance the phase, run the down-counter, and form the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= CNT_ZERO;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (taps_zero) begin
                            done_q <= 1'b1;
                        end else begin
                            cnt_q   <= taps_i;
                            state_q <= ST_FETCH_A;
                        end
                    end
                end
                ST_FETCH_A: state_q <= ST_FETCH_X;
                ST_FETCH_X: state_q <= ST_MAC;
                ST_MAC: begin
                    cnt_q   <= cnt_q - CNT_ONE;
                    state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (cnt_q != CNT_ZERO) begin
                        state_q <= ST_FETCH_A;
                    end else begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sop_addr_gen.sv
// Operand address generator. Keeps one pointer into the coefficient table
// and one into the sample table. It puts the matching pointer on the shared
// read port in each fetch phase and advances that pointer by one operand
// width in bytes.
// Assumes load, fetch_a and fetch_x are mutually exclusive.
module sop_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              fetch_a_i,
    input  logic              fetch_x_i,
    input  logic [ADDR_W-1:0] coef_ptr_i,
    input  logic [ADDR_W-1:0] samp_ptr_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o
);

    localparam int                STRIDE   = DATA_W / 8;
    localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(STRIDE);

    logic [ADDR_W-1:0] cptr_q;
    logic [ADDR_W-1:0] sptr_q;

    // Capture the start pointers and step each one after its own fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cptr_q <= '0;
            sptr_q <= '0;
        end else if (load_i) begin
            cptr_q <= coef_ptr_i;
            sptr_q <= samp_ptr_i;
        end else begin
            if (fetch_a_i) cptr_q <= cptr_q + STRIDE_A;
            if (fetch_x_i) sptr_q <= sptr_q + STRIDE_A;
        end
    end

    // Drive the shared read port from the pointer of the active fetch.
    always_comb begin
        rd_req_o  = fetch_a_i || fetch_x_i;
        rd_addr_o = fetch_x_i ? sptr_q : cptr_q;
    end

endmodule

// File: rtl/sop_mac.sv
// Multiply-accumulate datapath. Latches the coefficient returned one cycle
// after its fetch and multiplies it by the sample arriving in the next
// cycle. The product is added into a wrapping accumulator. The accumulator
// is copied to the result register only when a job finishes.
// Assumes read data is valid exactly one cycle after each request.
module sop_mac #(
    parameter int DATA_W     = 16,
    parameter int ACC_W      = 32,
    parameter bit SIGNED_MUL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              zero_i,
    input  logic              fetch_x_i,
    input  logic              mac_i,
    input  logic              finish_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ACC_W-1:0]  result_o
);

    localparam int PROD_W = 2 * DATA_W;

    logic [DATA_W-1:0] coef_q;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  res_q;
    logic [ACC_W-1:0]  prod_ext;

    // Choose the multiplier variant; sign or zero extend to the accumulator.
    generate
        if (SIGNED_MUL) begin : g_signed
            logic signed [PROD_W-1:0] prod;
            always_comb begin
                prod     = $signed(coef_q) * $signed(rd_data_i);
                prod_ext = ACC_W'(prod);
            end
        end else begin : g_unsigned
            logic [PROD_W-1:0] prod;
            always_comb begin
                prod     = coef_q * rd_data_i;
                prod_ext = ACC_W'(prod);
            end
        end
    endgenerate

    // Hold the coefficient, accumulate the terms, publish the final sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_q <= '0;
            acc_q  <= '0;
            res_q  <= '0;
        end else begin
            if (fetch_x_i) coef_q <= rd_data_i;
            if (clear_i || zero_i) acc_q <= '0;
            else if (mac_i) acc_q <= acc_q + prod_ext;
            if (zero_i) res_q <= '0;
            else if (finish_i) res_q <= acc_q;
        end
    end

    assign result_o = res_q;

endmodule

// File: rtl/sop_engine.sv
// Sum-of-products sequencer top. Ties the loop controller, the address
// generator and the multiply-accumulate datapath together around a single
// halfword read port with one cycle of read latency.
// Assumes halfword-aligned pointers and memory that answers every request.
module sop_engine #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] coef_ptr_i,
    input  logic [ADDR_W-1:0] samp_ptr_i,
    input  logic [CNT_W-1:0]  taps_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ACC_W-1:0]  result_o
);

    logic load;
    logic zero;
    logic fetch_a;
    logic fetch_x;
    logic mac;
    logic finish;

    sop_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .taps_i    (taps_i),
        .busy_o    (busy_o),
        .load_o    (load),
        .zero_o    (zero),
        .fetch_a_o (fetch_a),
        .fetch_x_o (fetch_x),
        .mac_o     (mac),
        .finish_o  (finish),
        .done_o    (done_o)
    );

    sop_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .fetch_a_i  (fetch_a),
        .fetch_x_i  (fetch_x),
        .coef_ptr_i (coef_ptr_i),
        .samp_ptr_i (samp_ptr_i),
        .rd_req_o   (rd_req_o),
        .rd_addr_o  (rd_addr_o)
    );

    sop_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SIGNED_MUL(1'b1)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (load),
        .zero_i    (zero),
        .fetch_x_i (fetch_x),
        .mac_i     (mac),
        .finish_i  (finish),
        .rd_data_i (rd_data_i),
        .result_o  (result_o)
    );

endmodule

// File: rtl/sop_engine_chk.sv
// Property checker for the sum-of-products sequencer, watching only the
// top-level ports. It is attached to every sop_engine instance by the bind
// statement at the end of this file.
module sop_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] coef_ptr_i,
    input logic [ADDR_W-1:0] samp_ptr_i,
    input logic [CNT_W-1:0]  taps_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic [DATA_W-1:0] rd_data_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [ACC_W-1:0]  result_o
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                              // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                              // R8
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> busy_o);                                             // R11
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));                                   // R9
    AST_ZERO_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && taps_i == '0) |=> (done_o && !rd_req_o));  // R6
    AST_FETCH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req_o) |=> (rd_req_o ##1 !rd_req_o));                    // R4

endmodule

bind sop_engine sop_engine_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
) u_sop_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .coef_ptr_i (coef_ptr_i),
    .samp_ptr_i (samp_ptr_i),
    .taps_i     (taps_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_data_i  (rd_data_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
);

// File: tb/test_sop_engine.sv
// Cycle-by-cycle bench: a behavioural model queues the expected port values
// for every cycle of a job and compares them at each falling edge.
module test_sop_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] coef_ptr;
    logic [31:0] samp_ptr;
    logic [15:0] taps;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic [15:0] rd_data;
    logic        busy;
    logic        done;
    logic [31:0] result;

    always #5 clk = ~clk;

    sop_engine i_sop_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .coef_ptr_i (coef_ptr),
        .samp_ptr_i (samp_ptr),
        .taps_i     (taps),
        .rd_req_o   (rd_req),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (result)
    );

    logic [15:0] mem [int unsigned];
    int total = 0;
    int bad   = 0;
    string tag = "R2";

    typedef struct {
        bit          req;
        logic [31:0] addr;
        bit          bsy;
        bit          dn;
        logic [31:0] res;
    } exp_t;

    exp_t        q[$];
    logic [31:0] held_res = 32'h0;

    function automatic logic [15:0] peek(logic [31:0] a);
        return mem.exists(a >> 1) ? mem[a >> 1] : 16'h0;
    endfunction

    // Memory with a fixed one-cycle read latency.
    always @(posedge clk) begin
        if (rd_req) rd_data <= peek(rd_addr);
    end

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Model: on an accepted start, queue the expected per-cycle port values.
    always @(posedge clk) begin
        if (rst_n && start && q.size() == 0) begin
            logic [31:0] acc;
            acc = 32'h0;
            for (int k = 0; k < int'(taps); k++) begin
                logic [31:0] ca;
                logic [31:0] sa;
                ca = coef_ptr + 32'(2 * k);
                sa = samp_ptr + 32'(2 * k);
                acc = acc + (int'($signed(peek(ca))) * int'($signed(peek(sa))));
                q.push_back('{1'b1, ca, 1'b1, 1'b0, 32'h0});
                q.push_back('{1'b1, sa, 1'b1, 1'b0, 32'h0});
                q.push_back('{1'b0, 32'h0, 1'b1, 1'b0, 32'h0});
                q.push_back('{1'b0, 32'h0, 1'b1, 1'b0, 32'h0});
            end
            q.push_back('{1'b0, 32'h0, 1'b0, 1'b1, acc});
        end
    end

    // Compare every output against the model each cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            if (q.size() > 0) e = q.pop_front();
            else e = '{1'b0, 32'h0, 1'b0, 1'b0, held_res};
            if (e.dn) held_res = e.res;
            chk("R11 rd_req", {31'h0, rd_req}, {31'h0, e.req});
            if (e.req) chk("R4 rd_addr", rd_addr, e.addr);
            chk("R5 busy", {31'h0, busy}, {31'h0, e.bsy});
            chk("R8 done", {31'h0, done}, {31'h0, e.dn});
            if (e.dn) chk({tag, " result"}, result, held_res);
            else      chk("R9 result hold", result, held_res);
        end
    end

    task automatic fill(logic [31:0] base, int n, int kind);
        for (int k = 0; k < n; k++) begin
            logic [15:0] v;
            case (kind)
                0: v = 16'($urandom);
                1: v = 16'h8000;
                default: v = 16'(k * 7 - 9);
            endcase
            mem[(base >> 1) + 32'(k)] = v;
        end
    endtask

    task automatic pulse(logic [31:0] c, logic [31:0] s, int n);
        @(posedge clk); #1;
        coef_ptr = c; samp_ptr = s; taps = 16'(n); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic run(logic [31:0] c, logic [31:0] s, int n, string t);
        tag = t;
        pulse(c, s, n);
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R5 watchdog actual=timeout expected=job completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; coef_ptr = '0; samp_ptr = '0; taps = '0;
        rd_data = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: synchronous reset state
        chk("R1 busy", {31'h0, busy}, 32'h0);
        chk("R1 done", {31'h0, done}, 32'h0);
        chk("R1 rd_req", {31'h0, rd_req}, 32'h0);
        chk("R1 result", result, 32'h0);
        rst_n = 1'b1;

        // R2: single term, 3 * -4
        mem[32'h1000 >> 1] = 16'd3;
        mem[32'h2000 >> 1] = 16'hFFFC;
        run(32'h1000, 32'h2000, 1, "R2");
        // R2: few terms of mixed sign
        fill(32'h1100, 3, 2);
        fill(32'h2100, 3, 0);
        run(32'h1100, 32'h2100, 3, "R2");
        // R2: typical 40-tap job with random data
        fill(32'h3000, 40, 0);
        fill(32'h5000, 40, 0);
        run(32'h3000, 32'h5000, 40, "R2");
        // R3: 4 * (0x8000 * 0x8000) wraps to 0, 5 terms give 0x40000000
        fill(32'h6000, 5, 1);
        fill(32'h7000, 5, 1);
        run(32'h6000, 32'h7000, 4, "R3");
        run(32'h6000, 32'h7000, 5, "R3");
        // R6: zero taps, no reads, result 0
        run(32'h1000, 32'h2000, 0, "R6");

        // R7: a second start during a job must be ignored
        tag = "R7";
        pulse(32'h1100, 32'h2100, 3);
        repeat (3) @(posedge clk);
        #1;
        coef_ptr = 32'h3000; samp_ptr = 32'h5000; taps = 16'd2; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_idle();

        // R10: start exactly in the done cycle is accepted
        tag = "R10";
        pulse(32'h3000, 32'h5000, 2);
        @(negedge clk);
        while (!done) @(negedge clk);
        #1;
        coef_ptr = 32'h1100; samp_ptr = 32'h2100; taps = 16'd3; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_idle();

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule